// File: doc/BRIEF.md
# Barrel Shift and Rotate Unit with Carry and Overflow Flags

This block is a purely combinational shifter for an integer execution pipe. It takes one operand, a shift count and an operation code, and returns the shifted or rotated value. Alongside the value it returns new carry, extended-carry and overflow values, with one write enable for each. The operand may be 8, 16, 32 or 64 bits wide. The count comes either from a register value or from an 8-bit immediate, and it is cut down to the width that the operand size allows. The carry flag currently held by the pipe enters as an input. It feeds the two rotate-through-carry operations and the overflow rules that depend on the old carry.

The flag register is outside this block. The pipe applies the returned flag values only where the matching write enable is high. The enables are low when flag updates were not requested, when the operation code is unused, or when the cut-down count is zero.

Top module: `barrel_flag_unit`

## Requirements
- R1: When `cnt_sel_imm`=1 the count is `cnt_imm`, otherwise it is `cnt_reg`. For a 64-bit operand the count is masked to its low 6 bits; for 8-, 16- and 32-bit operands it is masked to its low 5 bits. Bits above the mask have no effect.
- R2: When the masked count is zero, `res` equals the operand (the low operand-size bits of `src`) and all three flag write enables are 0, for every operation code.
- R3: `cf_we`, `ecf_we` and `of_we` are always equal to one another. They are 1 exactly when `flag_req`=1, the operation code is 0 to 6 and the masked count is non-zero. `ecf_out` always equals `cf_out`.
- R4: Operation 0 is a left shift that fills with zeros. The carry is the last bit shifted out, or 0 if the count exceeds the operand width. Overflow is that carry XOR the result MSB.
- R5: Operation 1 is a logical right shift that fills with zeros. The carry is the last bit shifted out. Overflow is the MSB of the original operand.
- R6: Operation 2 is an arithmetic right shift that fills with copies of the original MSB. The carry is the last bit shifted out, which is the sign bit once the count reaches the width. Overflow is 0.
- R7: Operation 3 rotates left by the count modulo the operand width. The carry is the result LSB. Overflow is the result MSB XOR the result LSB.
- R8: Operation 4 rotates right by the count modulo the operand width. The carry is the result MSB. Overflow is the XOR of the two top bits of the original operand.
- R9: Operation 5 rotates left through carry. It treats {carry, operand} as one value of width+1 and rotates it by the count modulo width+1. The carry becomes the bit that leaves the top. Overflow is the old carry XOR the result MSB.
- R10: Operation 6 rotates right through carry in the same width+1 value. The carry becomes the last bit rotated out of the bottom. Overflow is the old carry XOR the original operand MSB.
- R11: `osize` encodes 0=8, 1=16, 2=32 and 3=64 bits. Only the low operand-size bits of `src` are used, and every `res` bit above the operand size is 0.
- R12: Operation code 7 is unused. It returns the operand unchanged and asserts no flag write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 3 | Operation code (0..6 valid, 7 unused) |
| osize | input | 2 | Operand size code |
| src | input | 64 | Operand to shift or rotate |
| cnt_sel_imm | input | 1 | Selects the immediate count when 1 |
| cnt_reg | input | 64 | Count taken from a register |
| cnt_imm | input | 8 | Count taken from the immediate |
| cf_in | input | 1 | Current carry flag |
| flag_req | input | 1 | Caller requests flag updates |
| res | output | 64 | Shifted or rotated result, zero above operand size |
| cf_out | output | 1 | New carry value |
| ecf_out | output | 1 | New extended-carry value |
| of_out | output | 1 | New overflow value |
| cf_we | output | 1 | Carry write enable |
| ecf_we | output | 1 | Extended-carry write enable |
| of_we | output | 1 | Overflow write enable |

## Verification
The assertions sample the outputs only after the combinational inputs have settled. They also assume that every input bit holds a known 0 or 1, because they compare bits of `res` against the flag outputs. The bench changes the inputs only on the falling clock edge and waits a fixed delay before it samples, so every input is driven from the first vector onward. The bench then sweeps every size, every operation code including the unused one, every 6-bit count, both carry inputs and several data patterns. The unused high count bits carry junk and the unselected count source carries a different value, so the masking and the source selection are both exercised.

// File: rtl/bfu_pkg.sv
// Shared constants and encodings for the barrel/flag unit.
// Assumes a 64-bit datapath with operand sizes of 8, 16, 32 and 64 bits.
package bfu_pkg;
    parameter int DATA_W  = 64;
    parameter int IMM_W   = 8;
    localparam int CNT_W  = $clog2(DATA_W);       // 6-bit masked count
    localparam int N_SIZE = 4;                    // 8,16,32,64

    typedef enum logic [2:0] {
        OP_SHL  = 3'd0,
        OP_SHR  = 3'd1,
        OP_SAR  = 3'd2,
        OP_ROL  = 3'd3,
        OP_ROR  = 3'd4,
        OP_RCL  = 3'd5,
        OP_RCR  = 3'd6,
        OP_NONE = 3'd7
    } bfu_op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } bfu_size_e;
endpackage

// File: rtl/bfu_count.sv
// Count selection and masking.
// Picks the register or immediate count and keeps 6 bits for 64-bit
// operands or 5 bits for narrower ones. Assumes CNT_W = log2(DATA_W).
module bfu_count
    import bfu_pkg::*;
(
    input  logic              sel_imm,
    input  logic [DATA_W-1:0] cnt_reg,
    input  logic [IMM_W-1:0]  cnt_imm,
    input  logic [1:0]        osize,
    output logic [CNT_W-1:0]  cnt,
    output logic              cnt_zero
);
    logic [CNT_W-1:0] raw;

    // choose the count source and truncate to the datapath count width
    always_comb begin
        raw = sel_imm ? cnt_imm[CNT_W-1:0] : cnt_reg[CNT_W-1:0];
    end

    // mask the top count bit unless the operand is 64 bits wide
    always_comb begin
        cnt = raw;
        if (osize != SZ_64) cnt[CNT_W-1] = 1'b0;
        cnt_zero = (cnt == '0);
    end
endmodule

// File: rtl/bfu_lane.sv
// One operand-width lane: all shift and rotate kinds plus their carry and
// overflow rules for width W. Assumes W >= 2 and W <= 2**CNT_W.
// Last-bit-out is recovered from a double-width shift of the operand.
module bfu_lane
    import bfu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2:0]       op,
    input  logic [W-1:0]     src,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cf_in,
    output logic [W-1:0]     res,
    output logic             cf,
    output logic             of
);
    localparam int W2 = 2 * W;
    localparam int WC = W + 1;

    logic [W2-1:0]        shl_v, shr_v, rol_v, ror_v;
    logic signed [W2-1:0] sar_v;
    logic [CNT_W-1:0]     rot_amt, rc_amt;
    logic [W:0]           rc_v;
    logic [2*WC-1:0]      rcl_v, rcr_v;
    logic [W:0]           rcl_r, rcr_r;

    // plain rotate amount wraps at W, through-carry amount wraps at W+1
    always_comb begin
        rot_amt = CNT_W'(cnt % W);
        rc_amt  = CNT_W'(cnt % WC);
    end

    // double-width shifts keep the last bit moved out next to the result
    always_comb begin
        shl_v = {{W{1'b0}}, src} << cnt;
        shr_v = {src, {W{1'b0}}} >> cnt;
        sar_v = $signed({src, {W{1'b0}}}) >>> cnt;
        rol_v = {src, src} << rot_amt;
        ror_v = {src, src} >> rot_amt;
        rc_v  = {cf_in, src};
        rcl_v = {rc_v, rc_v} << rc_amt;
        rcr_v = {rc_v, rc_v} >> rc_amt;
        rcl_r = rcl_v[2*WC-1:WC];
        rcr_r = rcr_v[W:0];
    end

    // per-operation result, carry and overflow selection
    always_comb begin
        res = src;
        cf  = 1'b0;
        of  = 1'b0;
        case (op)
            OP_SHL: begin
                res = shl_v[W-1:0];
                cf  = shl_v[W];
                of  = shl_v[W] ^ shl_v[W-1];
            end
            OP_SHR: begin
                res = shr_v[W2-1:W];
                cf  = shr_v[W-1];
                of  = src[W-1];
            end
            OP_SAR: begin
                res = sar_v[W2-1:W];
                cf  = sar_v[W-1];
                of  = 1'b0;
            end
            OP_ROL: begin
                res = rol_v[W2-1:W];
                cf  = rol_v[W];
                of  = rol_v[W2-1] ^ rol_v[W];
            end
            OP_ROR: begin
                res = ror_v[W-1:0];
                cf  = ror_v[W-1];
                of  = src[W-1] ^ src[W-2];
            end
            OP_RCL: begin
                res = rcl_r[W-1:0];
                cf  = rcl_r[W];
                of  = cf_in ^ rcl_r[W-1];
            end
            OP_RCR: begin
                res = rcr_r[W-1:0];
                cf  = rcr_r[W];
                of  = cf_in ^ src[W-1];
            end
            default: begin
                res = src;
                cf  = cf_in;
                of  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/barrel_flag_unit.sv
// Top of the combinational shift/rotate unit.
// Builds one lane per operand size, selects by osize, zero-extends the
// result and gates the flag write enables. Assumes inputs are stable
// for the whole evaluation; no state is held.
module barrel_flag_unit
    import bfu_pkg::*;
(
    input  logic [2:0]        op,
    input  logic [1:0]        osize,
    input  logic [DATA_W-1:0] src,
    input  logic              cnt_sel_imm,
    input  logic [DATA_W-1:0] cnt_reg,
    input  logic [IMM_W-1:0]  cnt_imm,
    input  logic              cf_in,
    input  logic              flag_req,
    output logic [DATA_W-1:0] res,
    output logic              cf_out,
    output logic              ecf_out,
    output logic              of_out,
    output logic              cf_we,
    output logic              ecf_we,
    output logic              of_we
);
    logic [CNT_W-1:0]  cnt;
    logic              cnt_zero;
    logic [DATA_W-1:0] lane_res [N_SIZE];
    logic              lane_cf  [N_SIZE];
    logic              lane_of  [N_SIZE];
    logic              upd;

    bfu_count u_count (
        .sel_imm  (cnt_sel_imm),
        .cnt_reg  (cnt_reg),
        .cnt_imm  (cnt_imm),
        .osize    (osize),
        .cnt      (cnt),
        .cnt_zero (cnt_zero)
    );

    for (genvar g = 0; g < N_SIZE; g++) begin : g_lane
        localparam int LW = 8 << g;
        logic [LW-1:0] l_res;

        bfu_lane #(.W(LW)) u_lane (
            .op    (op),
            .src   (src[LW-1:0]),
            .cnt   (cnt),
            .cf_in (cf_in),
            .res   (l_res),
            .cf    (lane_cf[g]),
            .of    (lane_of[g])
        );

        // zero-extend the lane result to the datapath width
        always_comb lane_res[g] = DATA_W'(l_res);
    end

    // pick the lane matching the operand size and gate flag updates
    always_comb begin
        res     = lane_res[osize];
        cf_out  = lane_cf[osize];
        ecf_out = lane_cf[osize];
        of_out  = lane_of[osize];
        upd     = flag_req && !cnt_zero && (op != OP_NONE);
        cf_we   = upd;
        ecf_we  = upd;
        of_we   = upd;
    end
endmodule

// File: rtl/barrel_flag_chk.sv
// Property checker for barrel_flag_unit, attached by bind.
// Assumes inputs are known values and samples after settling.
module barrel_flag_chk
    import bfu_pkg::*;
(
    input logic [2:0]        op,
    input logic [1:0]        osize,
    input logic [DATA_W-1:0] src,
    input logic              cnt_sel_imm,
    input logic [DATA_W-1:0] cnt_reg,
    input logic [IMM_W-1:0]  cnt_imm,
    input logic              cf_in,
    input logic              flag_req,
    input logic [DATA_W-1:0] res,
    input logic              cf_out,
    input logic              ecf_out,
    input logic              of_out,
    input logic              cf_we,
    input logic              ecf_we,
    input logic              of_we
);
    logic [5:0]        c_mask;
    logic [DATA_W-1:0] w_mask;
    int unsigned       w_top;

    // reference count mask and width mask derived from the ports
    always_comb begin
        c_mask = cnt_sel_imm ? cnt_imm[5:0] : cnt_reg[5:0];
        if (osize != SZ_64) c_mask[5] = 1'b0;
        w_top  = (8 << osize) - 1;
        w_mask = (osize == SZ_64) ? '1 : ((DATA_W'(1) << (8 << osize)) - 1);
    end

    // property checks on settled values
    always_comb begin
        // R3
        we_group_chk: assert (cf_we == ecf_we && ecf_we == of_we && ecf_out == cf_out)
            else $error("enables or carry copies disagree");
        // R2
        zero_count_chk: assert (c_mask != 0 || (!cf_we && res == (src & w_mask)))
            else $error("zero count changed state");
        // R11
        upper_zero_chk: assert ((res & ~w_mask) == '0)
            else $error("result bits above operand size");
        // R6
        sar_of_chk: assert (!(op == OP_SAR && of_we) || !of_out)
            else $error("arithmetic shift overflow not cleared");
        // R7
        rol_cf_chk: assert (!(op == OP_ROL && cf_we) || cf_out == res[0])
            else $error("rotate left carry mismatch");
        // R8
        ror_cf_chk: assert (!(op == OP_ROR && cf_we) || cf_out == res[w_top])
            else $error("rotate right carry mismatch");
        // R12
        unused_op_chk: assert (op != OP_NONE || (!cf_we && res == (src & w_mask)))
            else $error("unused opcode had an effect");
    end
endmodule

bind barrel_flag_unit barrel_flag_chk i_chk (.*);

// File: tb/test_barrel_flag_unit.sv
module test_barrel_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  osize = '0;
    logic [63:0] src = '0;
    logic        cnt_sel_imm = 1'b0;
    logic [63:0] cnt_reg = '0;
    logic [7:0]  cnt_imm = '0;
    logic        cf_in = 1'b0;
    logic        flag_req = 1'b0;
    logic [63:0] res;
    logic        cf_out, ecf_out, of_out, cf_we, ecf_we, of_we;
    int          vectors = 0;
    int          miscompares = 0;

    always #2.5 clk = ~clk;

    barrel_flag_unit i_barrel_flag_unit (.*);

    // bit-serial reference: one step per count, flags from the rules
    task automatic model(input logic [2:0] m_op, input logic [1:0] m_sz,
                         input logic [63:0] m_src, input logic [5:0] m_raw,
                         input logic m_cf, output logic [63:0] m_res,
                         output logic m_c, output logic m_o, output logic m_we_ok);
        int w = 8 << m_sz;
        logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
        logic [63:0] x = m_src & mask;
        int c = (m_sz == 2'd3) ? int'(m_raw) : int'(m_raw[4:0]);
        logic cc = m_cf;
        logic b;
        m_c = 1'b0;
        for (int k = 0; k < c; k++) begin
            case (m_op)
                3'd0: begin m_c = x[w-1]; x = (x << 1) & mask; end
                3'd1: begin m_c = x[0]; x = x >> 1; end
                3'd2: begin m_c = x[0]; b = x[w-1]; x = (x >> 1) | (64'(b) << (w-1)); end
                3'd3: begin b = x[w-1]; x = ((x << 1) & mask) | 64'(b); end
                3'd4: begin b = x[0]; x = (x >> 1) | (64'(b) << (w-1)); end
                3'd5: begin b = x[w-1]; x = ((x << 1) & mask) | 64'(cc); cc = b; end
                3'd6: begin b = x[0]; x = (x >> 1) | (64'(cc) << (w-1)); cc = b; end
                default: ;
            endcase
        end
        m_res = x;
        case (m_op)
            3'd0: m_o = m_c ^ x[w-1];
            3'd1: m_o = m_src[w-1];
            3'd2: m_o = 1'b0;
            3'd3: begin m_c = x[0]; m_o = x[w-1] ^ x[0]; end
            3'd4: begin m_c = x[w-1]; m_o = m_src[w-1] ^ m_src[w-2]; end
            3'd5: begin m_c = cc; m_o = m_cf ^ x[w-1]; end
            3'd6: begin m_c = cc; m_o = m_cf ^ m_src[w-1]; end
            default: m_o = 1'b0;
        endcase
        m_we_ok = (c != 0) && (m_op != 3'd7);
    endtask

    function automatic string tag(input logic [2:0] t_op);
        case (t_op)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            3'd5: return "R9";
            3'd6: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s op=%0d sz=%0d src=%h cnt_imm=%h cnt_reg=%h: actual %h expected %h",
                     req, op, osize, src, cnt_imm, cnt_reg, act, exp);
        end
    endtask

    initial begin
        logic [63:0] pats [4];
        logic [63:0] e_res;
        logic        e_c, e_o, e_ok, e_we;
        pats[0] = 64'h8000_0000_0000_0001;
        pats[1] = 64'hA5C3_0F81_7E24_96DB;
        pats[2] = 64'h7FFF_FFFF_8000_4001;
        pats[3] = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state: all-zero inputs give zero result and no enables (R2)
        check("R2", {res[63:1], cf_we}, 64'd0);
        for (int p = 0; p < 4; p++)
            for (int sz = 0; sz < 4; sz++)
                for (int o = 0; o < 8; o++)
                    for (int c = 0; c < 64; c++)
                        for (int ci = 0; ci < 2; ci++) begin
                            @(negedge clk);
                            op          = 3'(o);
                            osize       = 2'(sz);
                            src         = pats[p] ^ {32'h0, 26'h0, 6'(c)};
                            cf_in       = ci[0];
                            flag_req    = !(p == 2 && c[0]);
                            cnt_sel_imm = c[1] ^ ci[0];
                            // R1: junk above the mask; the unselected source differs
                            if (cnt_sel_imm) begin
                                cnt_imm = {2'(p + 1), 6'(c)};
                                cnt_reg = {58'h2AB_CDEF_0123_45, 6'(c ^ 21)};
                            end else begin
                                cnt_reg = {58'h155_4321_FEDC_BA, 6'(c)};
                                cnt_imm = {2'(p), 6'(c ^ 42)};
                            end
                            #1;
                            model(op, osize, src, 6'(c), cf_in, e_res, e_c, e_o, e_ok);
                            e_we = e_ok && flag_req;
                            // R1 R11 result value with upper bits zero
                            check(tag(op), res, e_res);
                            // R3 enables grouped; R2 zero count suppresses
                            check("R3", {61'd0, cf_we, ecf_we, of_we}, {61'd0, e_we, e_we, e_we});
                            if (e_we) begin
                                check(tag(op), {62'd0, cf_out, ecf_out}, {62'd0, e_c, e_c});
                                check(tag(op), {63'd0, of_out}, {63'd0, e_o});
                            end
                        end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // watchdog ends a hung run as a failure
    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule